// File: doc/BRIEF.md
# Diagnostic Output Selector with Bypass Feedback Counter

This block drives one diagnostic pin from a 3-bit test code. The choices are constant levels, the serial shift-chain output and the synthesised output. The block also holds its own dividers, and some codes show their outputs on the pin. A power-of-two prescaler divides the reference clock by 16. The feedback counter is a fixed divide-by-4 stage followed by a 9-bit programmable counter. A second power-of-two stage divides the synthesised output by 4.

In normal operation the feedback counter and the external post-divider are clocked from the oscillator clock. One test code selects a bypass mode. In that mode a low-speed serial clock replaces the oscillator clock, so both dividers can be stepped on a board without the loop running. The change of source goes through a glitch-free switch. Each side of the switch has a two-flop enable handshake, and the flops toggle on falling edges.

The feedback counter emits a one-cycle pulse each time it wraps. The pulse period is 4·M source cycles. An M value of 0 or 1 is treated as 1.

Top module: `tsel_test_mux`

## Requirements
- R1: Code 000 drives test_o from shift_out_i, code 100 drives it from post_div_i, code 001 holds it at 1 and code 101 holds it at 0.
- R2: Code 010 drives test_o with the reference clock divided by 16: period 16 reference cycles, high for 8 of them.
- R3: Codes 011 and 110 drive test_o with the feedback pulse. The pulse is high for exactly one source-clock cycle, and its period is 4·M source-clock cycles, where M is the 9-bit m_val_i (up to 511).
- R4: An m_val_i of 0 or 1 gives a feedback pulse period of 4 source-clock cycles.
- R5: Code 111 drives test_o with post_div_i divided by 4, with a 50% duty cycle.
- R6: With code 110 held, div_src_clk_o follows sclk_i, so the feedback pulse period becomes 4·M serial-clock periods.
- R7: With any code other than 110 held, div_src_clk_o follows vco_clk_i.
- R8: When the source changes, no high or low phase of div_src_clk_o is shorter than half the oscillator period. The two source enables are never active together.
- R9: While rst_ni is low, all dividers are cleared, div_src_clk_o is low, and test_o is low for codes 010, 011 and 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_clk_i | input | 1 | Reference (crystal) clock |
| vco_clk_i | input | 1 | Oscillator clock, normal divider source |
| sclk_i | input | 1 | Serial clock, divider source in bypass |
| m_val_i | input | 9 | Feedback divide value M |
| t_code_i | input | 3 | Test code selecting the diagnostic source |
| shift_out_i | input | 1 | Serial output of the configuration shift chain |
| post_div_i | input | 1 | Synthesised output from the post-divider |
| test_o | output | 1 | Diagnostic output |
| div_src_clk_o | output | 1 | Clock feeding the post-divider and feedback counter |

## Verification
The pass-through and constant codes are tried with opposite levels on shift_out_i and post_div_i. This separates a correct selection from a stuck or swapped leg. The feedback counter is measured at M values of 0, 1, 5 and 511: 0 and 1 expose the clamp, 5 exposes an off-by-one in the reload, and 511 exposes a truncated counter. Bypass is entered and left while every phase width of the source clock is monitored. Comparing the measured periods against the oscillator and serial clocks shows which source drives the dividers. The prescaler paths are timed by their period and high time, which reveals a wrong ratio or duty cycle.

// File: rtl/tsel_pkg.sv
`timescale 1ns/1ps
package tsel_pkg;
  typedef enum logic [2:0] {
    TC_SHIFT  = 3'b000,
    TC_ONE    = 3'b001,
    TC_REFDIV = 3'b010,
    TC_FBDIV  = 3'b011,
    TC_FOUT   = 3'b100,
    TC_ZERO   = 3'b101,
    TC_BYPASS = 3'b110,
    TC_FOUT4  = 3'b111
  } test_code_e;
endpackage

// File: rtl/tsel_pow2_div.sv
`timescale 1ns/1ps
module tsel_pow2_div #(
  parameter int LOG2 = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic div_o
);
  logic [LOG2-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign div_o = cnt_q[LOG2-1];
endmodule

// File: rtl/tsel_clk_switch.sv
`timescale 1ns/1ps
module tsel_clk_switch #(
  parameter int STAGES = 2
) (
  input  logic rst_ni,
  input  logic clk_a_i,
  input  logic clk_b_i,
  input  logic sel_b_i,
  output logic clk_o,
  output logic en_a_o,
  output logic en_b_o
);
  logic [STAGES-1:0] a_sync_q, b_sync_q;
  logic              a_req, b_req;

  // each side may enable only once the other side reports idle
  assign a_req = ~sel_b_i & ~b_sync_q[STAGES-1];
  assign b_req =  sel_b_i & ~a_sync_q[STAGES-1];

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(negedge clk_a_i or negedge rst_ni) begin
        if (!rst_ni) a_sync_q <= '0;
        else         a_sync_q <= {a_sync_q[STAGES-2:0], a_req};
      end
      always_ff @(negedge clk_b_i or negedge rst_ni) begin
        if (!rst_ni) b_sync_q <= '0;
        else         b_sync_q <= {b_sync_q[STAGES-2:0], b_req};
      end
    end else begin : g_single
      always_ff @(negedge clk_a_i or negedge rst_ni) begin
        if (!rst_ni) a_sync_q <= '0;
        else         a_sync_q <= a_req;
      end
      always_ff @(negedge clk_b_i or negedge rst_ni) begin
        if (!rst_ni) b_sync_q <= '0;
        else         b_sync_q <= b_req;
      end
    end
  endgenerate

  assign en_a_o = a_sync_q[STAGES-1];
  assign en_b_o = b_sync_q[STAGES-1];
  assign clk_o  = (clk_a_i & en_a_o) | (clk_b_i & en_b_o);
endmodule

// File: rtl/tsel_fb_counter.sv
`timescale 1ns/1ps
module tsel_fb_counter #(
  parameter int M_W      = 9,
  parameter int PRE_LOG2 = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [M_W-1:0] m_val_i,
  output logic           pulse_o
);
  logic [PRE_LOG2-1:0] pre_q;
  logic [M_W-1:0]      cnt_q, last;
  logic                tick, wrap;

  // M of 0 or 1 behaves as divide-by-1
  assign last = (m_val_i <= M_W'(1)) ? '0 : m_val_i - M_W'(1);
  assign tick = &pre_q;
  assign wrap = tick && (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q   <= '0;
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      pre_q   <= pre_q + 1'b1;
      pulse_o <= wrap;
      if (tick) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tsel_test_mux.sv
`timescale 1ns/1ps
module tsel_test_mux
  import tsel_pkg::*;
#(
  parameter int M_W           = 9,
  parameter int REF_DIV_LOG2  = 4,
  parameter int FB_PRE_LOG2   = 2,
  parameter int FOUT_DIV_LOG2 = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic           rst_ni,
  input  logic           ref_clk_i,
  input  logic           vco_clk_i,
  input  logic           sclk_i,
  input  logic [M_W-1:0] m_val_i,
  input  logic [2:0]     t_code_i,
  input  logic           shift_out_i,
  input  logic           post_div_i,
  output logic           test_o,
  output logic           div_src_clk_o
);
  logic ref_div, fb_pulse, fout_div, src_clk, en_vco, en_scl, bypass;

  assign bypass = (t_code_i == TC_BYPASS);

  tsel_pow2_div #(.LOG2(REF_DIV_LOG2)) u_ref_div (
    .clk_i (ref_clk_i),
    .rst_ni(rst_ni),
    .div_o (ref_div)
  );

  tsel_clk_switch #(.STAGES(SYNC_STAGES)) u_switch (
    .rst_ni (rst_ni),
    .clk_a_i(vco_clk_i),
    .clk_b_i(sclk_i),
    .sel_b_i(bypass),
    .clk_o  (src_clk),
    .en_a_o (en_vco),
    .en_b_o (en_scl)
  );

  tsel_fb_counter #(.M_W(M_W), .PRE_LOG2(FB_PRE_LOG2)) u_fb (
    .clk_i  (src_clk),
    .rst_ni (rst_ni),
    .m_val_i(m_val_i),
    .pulse_o(fb_pulse)
  );

  tsel_pow2_div #(.LOG2(FOUT_DIV_LOG2)) u_fout_div (
    .clk_i (post_div_i),
    .rst_ni(rst_ni),
    .div_o (fout_div)
  );

  always_comb begin
    case (t_code_i)
      TC_SHIFT:           test_o = shift_out_i;
      TC_ONE:             test_o = 1'b1;
      TC_REFDIV:          test_o = ref_div;
      TC_FBDIV,
      TC_BYPASS:          test_o = fb_pulse;
      TC_FOUT:            test_o = post_div_i;
      TC_ZERO:            test_o = 1'b0;
      default:            test_o = fout_div;
    endcase
  end

  assign div_src_clk_o = src_clk;
endmodule

// File: rtl/tsel_test_mux_chk.sv
`timescale 1ns/1ps
module tsel_test_mux_chk (
  input logic       rst_ni,
  input logic       ref_clk_i,
  input logic       vco_clk_i,
  input logic       sclk_i,
  input logic       src_clk_i,
  input logic [2:0] t_code_i,
  input logic       test_o,
  input logic       ref_div_i,
  input logic       fb_pulse_i,
  input logic       en_vco_i,
  input logic       en_scl_i
);
  logic [4:0] run_q;
  logic       prev_q;

  // reference cycles spent at the current level of the prescaler output
  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      prev_q <= ref_div_i;
      if (ref_div_i != prev_q) run_q <= 5'd1;
      else if (run_q != 5'd31) run_q <= run_q + 5'd1;
    end
  end

  p_ref_half_r2: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (ref_div_i != prev_q) |-> (run_q == 5'd8));

  p_pulse_single_r3: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    fb_pulse_i |=> !fb_pulse_i);

  p_one_level_r1: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (t_code_i == 3'b001) |-> test_o);

  p_zero_level_r1: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (t_code_i == 3'b101) |-> !test_o);

  p_no_overlap_vco_r8: assert property (@(posedge vco_clk_i) disable iff (!rst_ni)
    !(en_vco_i && en_scl_i));

  p_no_overlap_scl_r8: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    !(en_vco_i && en_scl_i));
endmodule

bind tsel_test_mux tsel_test_mux_chk u_chk (
  .rst_ni    (rst_ni),
  .ref_clk_i (ref_clk_i),
  .vco_clk_i (vco_clk_i),
  .sclk_i    (sclk_i),
  .src_clk_i (src_clk),
  .t_code_i  (t_code_i),
  .test_o    (test_o),
  .ref_div_i (ref_div),
  .fb_pulse_i(fb_pulse),
  .en_vco_i  (en_vco),
  .en_scl_i  (en_scl)
);

// File: tb/sim_tsel_test_mux.sv
`timescale 1ns/1ps
module sim_tsel_test_mux;
  localparam realtime CLK_PERIOD = 10.0;   // reference clock
  localparam realtime VCO_PERIOD = 4.0;
  localparam realtime SCL_PERIOD = 26.0;
  localparam realtime PD_HALF    = 10.0;
  localparam realtime WD_LIMIT   = 100000.0 * CLK_PERIOD;

  logic       rst_ni, ref_clk, vco_clk, sclk;
  logic [8:0] m_val;
  logic [2:0] t_code;
  logic       shift_out, post_div, test_o, div_src_clk;
  logic       pd_run, mon_on;
  realtime    last_t, min_w;
  int         n_chk, n_bad;

  // {code[2:0], shift_out, post_div, expected}
  localparam logic [5:0] VEC [8] = '{
    6'b000_1_0_1, 6'b000_0_1_0, 6'b001_0_0_1, 6'b101_1_1_0,
    6'b100_0_1_1, 6'b100_1_0_0, 6'b001_0_1_1, 6'b101_0_0_0
  };

  tsel_test_mux u0 (
    .rst_ni(rst_ni), .ref_clk_i(ref_clk), .vco_clk_i(vco_clk), .sclk_i(sclk),
    .m_val_i(m_val), .t_code_i(t_code), .shift_out_i(shift_out),
    .post_div_i(post_div), .test_o(test_o), .div_src_clk_o(div_src_clk)
  );

  initial begin ref_clk = 0; #0.3; forever #(CLK_PERIOD/2) ref_clk = ~ref_clk; end
  initial begin vco_clk = 0; forever #(VCO_PERIOD/2) vco_clk = ~vco_clk; end
  initial begin sclk = 0; #0.6; forever #(SCL_PERIOD/2) sclk = ~sclk; end
  initial begin #0.7; forever begin #(PD_HALF); if (pd_run) post_div = ~post_div; end end

  always @(div_src_clk) begin
    if (mon_on) begin
      if (last_t > 0.0 && ($realtime - last_t) < min_w) min_w = $realtime - last_t;
      last_t = $realtime;
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(WD_LIMIT);
    n_bad++;
    $display("FAIL watchdog: run hung, got timeout exp completion");
    summary();
    $finish;
  end

  task automatic chk_bit(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b exp %b", req, got, exp);
    end
  endtask

  task automatic chk_time(input string req, input realtime got, input realtime exp);
    n_chk++;
    if (got < exp - 0.05 || got > exp + 0.05) begin
      n_bad++;
      $display("FAIL %s: got %0.2f exp %0.2f", req, got, exp);
    end
  endtask

  // which: 0 = test_o, 1 = div_src_clk; skips one full period first
  task automatic measure(input int which, output realtime per, output realtime hi);
    realtime t0, t1, t2;
    if (which == 0) begin
      @(posedge test_o); @(posedge test_o); t0 = $realtime;
      @(negedge test_o); t1 = $realtime;
      @(posedge test_o); t2 = $realtime;
    end else begin
      @(posedge div_src_clk); @(posedge div_src_clk); t0 = $realtime;
      @(negedge div_src_clk); t1 = $realtime;
      @(posedge div_src_clk); t2 = $realtime;
    end
    per = t2 - t0;
    hi  = t1 - t0;
  endtask

  initial begin
    realtime per, hi;
    n_chk = 0; n_bad = 0;
    rst_ni = 0; m_val = 9'd5; t_code = 3'b010; shift_out = 0; post_div = 0;
    pd_run = 0; mon_on = 0; last_t = 0.0; min_w = 1.0e9;

    // R9: reset state
    #50;
    chk_bit("R9 refdiv in reset", test_o, 1'b0);
    t_code = 3'b011; #1;
    chk_bit("R9 fb pulse in reset", test_o, 1'b0);
    t_code = 3'b111; #1;
    chk_bit("R9 fout div4 in reset", test_o, 1'b0);
    chk_bit("R9 source clock in reset", div_src_clk, 1'b0);
    rst_ni = 1;
    #40;

    // R1: static selection vectors
    foreach (VEC[i]) begin
      t_code = VEC[i][5:3]; shift_out = VEC[i][2]; post_div = VEC[i][1];
      #3;
      chk_bit($sformatf("R1 vector %0d", i), test_o, VEC[i][0]);
    end

    // R2: reference divided by 16
    t_code = 3'b010;
    measure(0, per, hi);
    chk_time("R2 refdiv period", per, 16.0 * CLK_PERIOD);
    chk_time("R2 refdiv high", hi, 8.0 * CLK_PERIOD);

    // R3 / R7: feedback pulse from the oscillator clock
    t_code = 3'b011; m_val = 9'd5;
    measure(0, per, hi);
    chk_time("R3 fb period M=5", per, 4.0 * 5.0 * VCO_PERIOD);
    chk_time("R3 fb pulse width", hi, VCO_PERIOD);
    measure(1, per, hi);
    chk_time("R7 source follows vco", per, VCO_PERIOD);

    // R4: clamp of small M
    m_val = 9'd0;
    measure(0, per, hi);
    chk_time("R4 fb period M=0", per, 4.0 * VCO_PERIOD);
    m_val = 9'd1;
    measure(0, per, hi);
    chk_time("R4 fb period M=1", per, 4.0 * VCO_PERIOD);

    // R3: full counter width
    m_val = 9'd511;
    measure(0, per, hi);
    chk_time("R3 fb period M=511", per, 4.0 * 511.0 * VCO_PERIOD);

    // R6 / R8: enter bypass, watch phase widths
    m_val = 9'd3;
    last_t = 0.0; min_w = 1.0e9; mon_on = 1;
    t_code = 3'b110;
    #(20.0 * SCL_PERIOD);
    measure(1, per, hi);
    chk_time("R6 source follows sclk", per, SCL_PERIOD);
    measure(0, per, hi);
    chk_time("R6 bypass fb period", per, 4.0 * 3.0 * SCL_PERIOD);
    chk_time("R6 bypass fb width", hi, SCL_PERIOD);
    t_code = 3'b011;
    #(10.0 * SCL_PERIOD);
    mon_on = 0;
    n_chk++;
    if (min_w < VCO_PERIOD / 2 - 0.05) begin
      n_bad++;
      $display("FAIL R8 shortest phase: got %0.2f exp >= %0.2f", min_w, VCO_PERIOD / 2);
    end
    measure(1, per, hi);
    chk_time("R7 source back on vco", per, VCO_PERIOD);

    // R5: post-divider output divided by 4
    t_code = 3'b111; pd_run = 1;
    measure(0, per, hi);
    chk_time("R5 fout div4 period", per, 8.0 * PD_HALF);
    chk_time("R5 fout div4 high", hi, 4.0 * PD_HALF);
    pd_run = 0;

    summary();
    $finish;
  end
endmodule